// File: doc/BRIEF.md
# Flash Write-Status Bit-7 Poller

This block forms the status path of a behavioural NOR-flash model. After the last write of a program or erase command, the command decoder pulses `start_i` and supplies the operation kind, the target address and data, and the protection verdict. From then on, reads from the host return a polling byte. Bit 7 of that byte reports how far the embedded operation has progressed. Bits 6..0 come from the array read path without change, because the other status bits are made elsewhere.

A program reports the inverse of the bit 7 value being written until the engine drops its busy flag. The block then returns to array reads, so the true value shows. An erase reports 0 while it runs and 1 once it is suspended. When the target is protected, the status is driven for a fixed window: about 1 µs for a program, or about 100 µs when every sector of an erase is protected. A cycle counter times the window, and its limits are derived from the clock frequency. The status appears only for reads at the program address, or for reads inside a sector that the erase has selected. Every other read returns array data.

Top module: `flash_poll_status`

## Requirements
- R1: Out of reset and whenever no operation is active, `array_mode_o` is 1 and `rd_data_o` equals `arr_data_i`.
- R2: From the cycle after an accepted program start without protection, `array_mode_o` is 0. A read whose `rd_addr_i` equals the latched program address returns bit 7 as the inverse of bit 7 of the latched program data, and bits 6..0 from `arr_data_i`.
- R3: While a program runs, a clock edge at which `busy_i` is 0 ends the operation. If the program was started from idle, array mode returns in the next cycle.
- R4: While an unprotected erase runs (including an erase with only some sectors protected), a read with `rd_in_sel_i`=1 returns bit 7 = 0. An edge with `busy_i`=0 and `susp_i`=0 returns to array mode.
- R5: An edge during an erase with `susp_i`=1 enters suspend. In suspend, reads with `rd_in_sel_i`=1 return bit 7 = 1. An edge in suspend with `susp_i`=0 and no accepted start resumes the erase.
- R6: A program start accepted in suspend uses the inverted-bit status of R2. When it ends, the block goes back to suspend rather than to array mode.
- R7: A program start with `prot_hit_i`=1 drives program status for exactly PROG_PROT_NS·CLK_MHZ/1000 cycles (200 by default), whatever `busy_i` does. It then returns to array mode, or to suspend if it was started in suspend.
- R8: An erase start with `prot_hit_i`=1 (all selected sectors protected) drives erase status (bit 7 = 0) for exactly ERASE_PROT_NS·CLK_MHZ/1000 cycles (20000 by default). It then returns to array mode.
- R9: While an operation is active, a read at a non-matching address (program) or with `rd_in_sel_i`=0 (erase, suspend) returns `arr_data_i` unchanged.
- R10: `start_i` is ignored while a program, an erase or a protected window is active. In suspend, an erase start is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse at the end of a command sequence |
| op_erase_i | input | 1 | 1 = erase, 0 = program (sampled with start) |
| prot_hit_i | input | 1 | Program target protected / all erase sectors protected |
| susp_i | input | 1 | Erase-suspend request level |
| busy_i | input | 1 | Algorithm engine busy |
| op_addr_i | input | AW | Program address (sampled with start) |
| prog_data_i | input | 8 | Program data byte (sampled with start) |
| rd_addr_i | input | AW | Current read address |
| rd_in_sel_i | input | 1 | Read address lies in a sector selected for erase |
| arr_data_i | input | 8 | Array read data |
| rd_data_o | output | 8 | Read data returned to the host |
| array_mode_o | output | 1 | 1 when reads return plain array data |

## Verification
The bench aims at the edges of each protected window. A timer that is off by one would let status leak one cycle early or late at cycle 200 or cycle 20000. It also tests the return from a program started during suspend: a design that dropped to array mode there would show bit 7 as array data instead of 1. Starts arrive during an active erase and during suspend to catch a block that restarts or changes operation. Addresses that hit and miss are mixed through every phase, so a status bit that leaked onto the wrong address is caught in the same cycle.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;
  typedef enum logic [2:0] {
    ST_ARRAY = 3'd0,
    ST_PROG  = 3'd1,
    ST_PPROT = 3'd2,
    ST_ERASE = 3'd3,
    ST_EPROT = 3'd4,
    ST_SUSP  = 3'd5
  } poll_st_t;

  function automatic int ns_to_cyc(input int ns, input int mhz);
    return (ns * mhz) / 1000;
  endfunction

  function automatic logic is_prog(input poll_st_t s);
    return (s == ST_PROG) || (s == ST_PPROT);
  endfunction

  function automatic logic status_bit(input poll_st_t s, input logic d7);
    logic b;
    case (s)
      ST_PROG, ST_PPROT: b = ~d7;
      ST_SUSP:           b = 1'b1;
      default:           b = 1'b0;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/flash_poll_timer.sv
module flash_poll_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          run_i,
  input  logic [CW-1:0] limit_i,
  output logic          done_o
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (load_i) cnt <= '0;
    else if (run_i)  cnt <= cnt + 1'b1;
  end

  assign done_o = run_i && (cnt == limit_i - 1'b1);

  // R7 / R8: the window never runs past its terminal count
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt < limit_i));
endmodule

// File: rtl/flash_poll_fsm.sv
module flash_poll_fsm
  import flash_poll_pkg::*;
#(
  parameter int AW     = 16,
  parameter int PP_CYC = 200,
  parameter int EP_CYC = 20000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          op_erase_i,
  input  logic          prot_hit_i,
  input  logic          susp_i,
  input  logic          busy_i,
  input  logic [AW-1:0] op_addr_i,
  input  logic [7:0]    prog_data_i,
  output poll_st_t      state_o,
  output logic [AW-1:0] addr_o,
  output logic          d7_o
);
  localparam int CW = $clog2(EP_CYC + 1) + 1;

  poll_st_t      st, st_nx;
  logic          from_susp;
  logic          win_done;
  logic          take_prog, take_erase, load_win;
  logic [CW-1:0] limit;

  // named events for assertions
  assign take_prog  = start_i && !op_erase_i && ((st == ST_ARRAY) || (st == ST_SUSP));
  assign take_erase = start_i && op_erase_i && (st == ST_ARRAY);
  assign load_win   = (take_prog || take_erase) && prot_hit_i;
  assign limit      = (st == ST_EPROT) ? CW'(EP_CYC) : CW'(PP_CYC);

  flash_poll_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load_win),
    .run_i   ((st == ST_PPROT) || (st == ST_EPROT)),
    .limit_i (limit),
    .done_o  (win_done)
  );

  always_comb begin
    st_nx = st;
    case (st)
      ST_ARRAY: begin
        if (take_prog)       st_nx = prot_hit_i ? ST_PPROT : ST_PROG;
        else if (take_erase) st_nx = prot_hit_i ? ST_EPROT : ST_ERASE;
      end
      ST_PROG:  if (!busy_i)  st_nx = from_susp ? ST_SUSP : ST_ARRAY;
      ST_PPROT: if (win_done) st_nx = from_susp ? ST_SUSP : ST_ARRAY;
      ST_ERASE: begin
        if (susp_i)       st_nx = ST_SUSP;
        else if (!busy_i) st_nx = ST_ARRAY;
      end
      ST_EPROT: if (win_done) st_nx = ST_ARRAY;
      ST_SUSP: begin
        if (take_prog)    st_nx = prot_hit_i ? ST_PPROT : ST_PROG;
        else if (!susp_i) st_nx = ST_ERASE;
      end
      default:  st_nx = ST_ARRAY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_ARRAY;
      from_susp <= 1'b0;
      addr_o    <= '0;
      d7_o      <= 1'b0;
    end else begin
      st <= st_nx;
      if (take_prog) begin
        from_susp <= (st == ST_SUSP);
        addr_o    <= op_addr_i;
        d7_o      <= prog_data_i[7];
      end
    end
  end

  assign state_o = st;

  p_prog_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ARRAY && start_i && !op_erase_i && !prot_hit_i) |=> (st == ST_PROG));
  p_susp_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ERASE && susp_i) |=> (st == ST_SUSP));
  p_resume_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SUSP && !susp_i && !start_i) |=> (st == ST_ERASE));
  p_ignore_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ERASE && !susp_i && busy_i) |=> (st == ST_ERASE));
  p_prog_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PROG && !busy_i) |=> (st == ST_ARRAY || st == ST_SUSP));
endmodule

// File: rtl/flash_poll_mux.sv
module flash_poll_mux
  import flash_poll_pkg::*;
#(
  parameter int AW = 16
) (
  input  poll_st_t      state_i,
  input  logic [AW-1:0] op_addr_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic          d7_i,
  input  logic          in_sel_i,
  input  logic [7:0]    arr_i,
  output logic [7:0]    rd_o,
  output logic          array_mode_o
);
  logic hit;

  always_comb begin
    if (state_i == ST_ARRAY)    hit = 1'b0;
    else if (is_prog(state_i))  hit = (rd_addr_i == op_addr_i);
    else                        hit = in_sel_i;
  end

  assign rd_o         = hit ? {status_bit(state_i, d7_i), arr_i[6:0]} : arr_i;
  assign array_mode_o = (state_i == ST_ARRAY);
endmodule

// File: rtl/flash_poll_status.sv
module flash_poll_status
  import flash_poll_pkg::*;
#(
  parameter int AW            = 16,
  parameter int CLK_MHZ       = 200,
  parameter int PROG_PROT_NS  = 1000,
  parameter int ERASE_PROT_NS = 100000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          op_erase_i,
  input  logic          prot_hit_i,
  input  logic          susp_i,
  input  logic          busy_i,
  input  logic [AW-1:0] op_addr_i,
  input  logic [7:0]    prog_data_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic          rd_in_sel_i,
  input  logic [7:0]    arr_data_i,
  output logic [7:0]    rd_data_o,
  output logic          array_mode_o
);
  localparam int PP_CYC = ns_to_cyc(PROG_PROT_NS, CLK_MHZ);
  localparam int EP_CYC = ns_to_cyc(ERASE_PROT_NS, CLK_MHZ);

  poll_st_t      st;
  logic [AW-1:0] tgt_addr;
  logic          tgt_d7;

  flash_poll_fsm #(.AW(AW), .PP_CYC(PP_CYC), .EP_CYC(EP_CYC)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .op_erase_i  (op_erase_i),
    .prot_hit_i  (prot_hit_i),
    .susp_i      (susp_i),
    .busy_i      (busy_i),
    .op_addr_i   (op_addr_i),
    .prog_data_i (prog_data_i),
    .state_o     (st),
    .addr_o      (tgt_addr),
    .d7_o        (tgt_d7)
  );

  flash_poll_mux #(.AW(AW)) u_mux (
    .state_i      (st),
    .op_addr_i    (tgt_addr),
    .rd_addr_i    (rd_addr_i),
    .d7_i         (tgt_d7),
    .in_sel_i     (rd_in_sel_i),
    .arr_i        (arr_data_i),
    .rd_o         (rd_data_o),
    .array_mode_o (array_mode_o)
  );

  p_passthru_r1: assert property (@(posedge clk) disable iff (!rst_n)
    array_mode_o |-> (rd_data_o == arr_data_i));
  p_low_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_o[6:0] == arr_data_i[6:0]);
endmodule

// File: tb/flash_poll_status_tb.sv
module flash_poll_status_tb;
  localparam int AW = 16;
  localparam int PP = 1000 * 200 / 1000;
  localparam int EP = 100000 * 200 / 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, op_erase = 1'b0, prot = 1'b0, susp = 1'b0, busy = 1'b0, in_sel = 1'b0;
  logic [AW-1:0] op_addr = '0, rd_addr = '0;
  logic [7:0] pdata = '0, arr = '0;
  logic [7:0] rd_data;
  logic array_mode;

  always #2.5 clk = ~clk;

  flash_poll_status u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .op_erase_i(op_erase),
    .prot_hit_i(prot), .susp_i(susp), .busy_i(busy), .op_addr_i(op_addr),
    .prog_data_i(pdata), .rd_addr_i(rd_addr), .rd_in_sel_i(in_sel),
    .arr_data_i(arr), .rd_data_o(rd_data), .array_mode_o(array_mode)
  );

  // reference model: mode 0 idle,1 prog,2 prog-window,3 erase,4 erase-window,5 suspend
  int m_mode = 0;
  int m_left = 0;
  bit m_back = 0;
  logic [AW-1:0] m_addr = '0;
  bit m_inv = 0;
  int vecs = 0, errs = 0, cycles = 0;
  string cur = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_left = 0; m_back = 0;
    end else begin
      bit accept_p;
      accept_p = start && !op_erase && (m_mode == 0 || m_mode == 5);
      if (accept_p) begin
        m_back = (m_mode == 5); m_addr = op_addr; m_inv = ~pdata[7];
        if (prot) begin m_mode = 2; m_left = PP; end else m_mode = 1;
      end else if (m_mode == 0 && start && op_erase) begin
        if (prot) begin m_mode = 4; m_left = EP; end else m_mode = 3;
      end else if (m_mode == 1) begin
        if (!busy) m_mode = m_back ? 5 : 0;
      end else if (m_mode == 2 || m_mode == 4) begin
        m_left--;
        if (m_left == 0) m_mode = (m_mode == 2 && m_back) ? 5 : 0;
      end else if (m_mode == 3) begin
        if (susp) m_mode = 5; else if (!busy) m_mode = 0;
      end else if (m_mode == 5) begin
        if (!susp) m_mode = 3;
      end
    end
  end

  always @(negedge clk) begin
    logic [7:0] e;
    bit em;
    cycles++;
    e = arr; em = (m_mode == 0);
    if ((m_mode == 1 || m_mode == 2) && rd_addr == m_addr) e[7] = m_inv;
    if ((m_mode == 3 || m_mode == 4) && in_sel) e[7] = 1'b0;
    if (m_mode == 5 && in_sel) e[7] = 1'b1;
    vecs++;
    if (rd_data !== e || array_mode !== em) begin
      errs++;
      $display("FAIL %s t=%0t rd_data=%h array_mode=%b expected %h %b",
               cur, $time, rd_data, array_mode, e, em);
    end
    if (cycles > 150000) begin
      errs++;
      $display("FAIL watchdog expired in %s", cur);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  task automatic tick(input int n, input bit jitter);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      arr = 8'($urandom);
      if (jitter) begin
        rd_addr = ($urandom % 2) ? op_addr : 16'($urandom);
        in_sel  = 1'($urandom);
      end
    end
  endtask

  task automatic go(input bit er, input bit pr, input logic [AW-1:0] a, input logic [7:0] d);
    op_erase = er; prot = pr; op_addr = a; pdata = d; start = 1'b1;
    tick(1, 1);
    start = 1'b0;
  endtask

  initial begin
    tick(3, 0);
    rst_n = 1'b1;
    cur = "R1"; tick(20, 1);
    // program, bit7 = 1 then 0
    busy = 1'b1; cur = "R2"; go(0, 0, 16'h0123, 8'hA5); tick(30, 1);
    cur = "R9"; rd_addr = 16'h0124; tick(5, 0);
    cur = "R3"; busy = 1'b0; tick(10, 1);
    busy = 1'b1; cur = "R2"; go(0, 0, 16'hBEEF, 8'h3C); tick(25, 1);
    cur = "R3"; busy = 1'b0; tick(5, 1);
    // erase with stray starts
    busy = 1'b1; cur = "R4"; go(1, 0, 16'h0000, 8'h00); tick(20, 1);
    cur = "R10"; go(0, 0, 16'h1111, 8'h80); tick(5, 1); go(1, 1, 16'h2222, 8'h00); tick(5, 1);
    cur = "R4"; busy = 1'b0; tick(10, 1);
    // erase with suspend and nested program
    busy = 1'b1; cur = "R5"; go(1, 0, 16'h0000, 8'h00); tick(8, 1);
    susp = 1'b1; tick(15, 1);
    cur = "R10"; go(1, 0, 16'h0000, 8'h00); tick(5, 1);
    cur = "R6"; go(0, 0, 16'h4242, 8'h7F); tick(12, 1);
    busy = 1'b0; tick(1, 1); busy = 1'b1; tick(10, 1);
    cur = "R5"; susp = 1'b0; tick(12, 1);
    cur = "R4"; busy = 1'b0; tick(8, 1);
    // protected program, busy ignored
    cur = "R7"; go(0, 1, 16'h0777, 8'hFF); tick(PP + 10, 1);
    busy = 1'b1; go(0, 1, 16'h0778, 8'h01); busy = 1'b0; tick(PP + 10, 1);
    // protected program from suspend
    busy = 1'b1; go(1, 0, 16'h0000, 8'h00); tick(3, 1); susp = 1'b1; tick(3, 1);
    cur = "R7"; go(0, 1, 16'h0999, 8'h80); tick(PP + 8, 1);
    susp = 1'b0; tick(3, 1); busy = 1'b0; tick(4, 1);
    // all-protected erase
    cur = "R8"; go(1, 1, 16'h0000, 8'h00); tick(EP + 20, 1);
    cur = "R1"; tick(10, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule